// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the sixteen general registers of a 32-bit processor core together with its current status word. It also keeps the shadow copies that privileged operating modes need. Each privileged mode owns its own stack pointer (r13), link register (r14) and saved status word. The fast-interrupt mode additionally owns a private set of r8 to r12.

The execute stage reads operands through two combinational ports and retires results through one synchronous write port. Writing the status word with a new mode field switches banks on that clock edge. From the next cycle on, every access sees the registers of the new mode.

Privileged instructions that must reach the user-mode registers from another mode use a separate user-view port. A status write that carries an illegal mode encoding is dropped, and the block raises an error flag.

Top module: `bankedRegFile`

## Requirements
- R1: While reset is held low, and after it is released, every general register, every shadow register and every saved status word reads zero, and the status word reads 0x0000001F (system mode).
- R2: The legal mode codes in status bits 4:0 are 10000 user, 10001 fast interrupt, 10010 interrupt, 10011 supervisor, 10111 abort, 11011 undefined and 11111 system. A status write with any other code leaves the status word and the bank selection unchanged, and `modeErr` is high in the following cycle only.
- R3: In fast-interrupt mode, r8 to r12 address a private copy. In every other mode they address the common copy.
- R4: Supervisor, abort, undefined, interrupt and fast-interrupt mode each have their own r13 and r14. User and system mode share one pair.
- R5: Only the five privileged exception modes have a saved status word. In those modes `hasSpsr` is 1 and `spsrOut` shows that mode's word. In user or system mode, `hasSpsr` and `spsrOut` are zero and `spsrWrEn` has no effect.
- R6: r0 to r7 and r15 are the same registers in every mode.
- R7: The user-view port reaches r8 to r12 of the common copy, and r13 and r14 of the user/system pair, whatever the current mode. Other indices behave as on the normal ports.
- R8: A register write or saved-status write in the same cycle as a legal mode change lands in the incoming mode's bank.
- R9: A legal status write loads all 32 bits at the next edge. Reads in the following cycle already see the new mode's bank.
- R10: `privileged` is 1 in every mode except user.
- R11: Both read ports are combinational. A write is visible on them from the cycle after its edge. If the normal and user-view write ports hit the same physical register, the normal port wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| rdAddrA | input | 4 | Read port A register index |
| rdDataA | output | 32 | Read port A data, current-mode view |
| rdAddrB | input | 4 | Read port B register index |
| rdDataB | output | 32 | Read port B data, current-mode view |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 4 | Register write index |
| wrData | input | 32 | Register write data |
| usrRdAddr | input | 4 | User-view read index |
| usrRdData | output | 32 | User-view read data |
| usrWrEn | input | 1 | User-view write enable |
| usrWrAddr | input | 4 | User-view write index |
| usrWrData | input | 32 | User-view write data |
| psrWrEn | input | 1 | Status word write enable |
| psrWrData | input | 32 | New status word |
| spsrWrEn | input | 1 | Saved status write enable |
| spsrWrData | input | 32 | Saved status data |
| cpsrOut | output | 32 | Current status word |
| spsrOut | output | 32 | Saved status word of the current mode, zero if none |
| hasSpsr | output | 1 | Current mode owns a saved status word |
| privileged | output | 1 | Current mode is not user |
| modeErr | output | 1 | Previous cycle's status write had an illegal mode |

## Verification
Directed steps first fill the common registers in system mode. They then hop through fast-interrupt, interrupt, user, supervisor and abort mode, reading r8, r13 and r14 after each hop. This separates a missing fast-interrupt copy from a wrong r13/r14 bank, and a shared user/system pair from a split one.

Same-cycle combinations of mode change with a register write, a saved-status write and a user-view write show whether writes land in the incoming or the outgoing bank. Illegal mode codes and saved-status writes in user and system mode check that nothing is disturbed.

A long stretch of random mode hops and writes on all ports, compared every cycle against a behavioural model, then covers combinations the directed steps miss.

// File: rtl/bankRegPkg.sv
package bankRegPkg;

  localparam int REG_ADDR_W = 4;
  localparam int NUM_PRIV   = 5;

  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;
  localparam logic [4:0] MODE_SYS = 5'b11111;

  // Physical bank selector: user/system share slot 0
  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_SVC = 3'd1,
    BK_ABT = 3'd2,
    BK_UND = 3'd3,
    BK_IRQ = 3'd4,
    BK_FIQ = 3'd5
  } bankT;

  typedef struct packed {
    logic gprWr;
    logic usrWr;
    logic spsrWr;
    logic cpsrLoad;
    bankT curBank;
    bankT wrBank;
  } strobeT;

  function automatic logic modeLegal(input logic [4:0] m);
    return (m == MODE_USR) || (m == MODE_FIQ) || (m == MODE_IRQ) ||
           (m == MODE_SVC) || (m == MODE_ABT) || (m == MODE_UND) ||
           (m == MODE_SYS);
  endfunction

  function automatic bankT modeToBank(input logic [4:0] m);
    bankT b;
    case (m)
      MODE_SVC: b = BK_SVC;
      MODE_ABT: b = BK_ABT;
      MODE_UND: b = BK_UND;
      MODE_IRQ: b = BK_IRQ;
      MODE_FIQ: b = BK_FIQ;
      default:  b = BK_USR;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/bankCtrl.sv
module bankCtrl
  import bankRegPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [4:0] curMode,
  input  logic       psrWrEn,
  input  logic [4:0] psrWrMode,
  input  logic       wrEn,
  input  logic       usrWrEn,
  input  logic       spsrWrEn,
  output strobeT     stb,
  output logic       modeErr,
  output logic       hasSpsr,
  output logic       privileged
);

  logic newLegal;
  bankT curBank;
  bankT wrBank;

  assign newLegal = modeLegal(psrWrMode);
  assign curBank  = modeToBank(curMode);
  // Writes issued alongside a legal mode change target the incoming bank
  assign wrBank   = (psrWrEn && newLegal) ? modeToBank(psrWrMode) : curBank;

  always_comb begin
    stb.gprWr    = wrEn;
    stb.usrWr    = usrWrEn;
    stb.spsrWr   = spsrWrEn && (wrBank != BK_USR);
    stb.cpsrLoad = psrWrEn && newLegal;
    stb.curBank  = curBank;
    stb.wrBank   = wrBank;
  end

  assign hasSpsr    = (curBank != BK_USR);
  assign privileged = (curMode != MODE_USR);

  always_ff @(posedge clk) begin
    if (!rstN) modeErr <= 1'b0;
    else       modeErr <= psrWrEn && !newLegal;
  end

endmodule

// File: rtl/bankDatapath.sv
module bankDatapath
  import bankRegPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobeT                stb,
  input  logic [REG_ADDR_W-1:0] rdAddrA,
  input  logic [REG_ADDR_W-1:0] rdAddrB,
  input  logic [REG_ADDR_W-1:0] usrRdAddr,
  input  logic [REG_ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [REG_ADDR_W-1:0] usrWrAddr,
  input  logic [DATA_W-1:0]     usrWrData,
  input  logic [DATA_W-1:0]     psrWrData,
  input  logic [DATA_W-1:0]     spsrWrData,
  output logic [DATA_W-1:0]     rdDataA,
  output logic [DATA_W-1:0]     rdDataB,
  output logic [DATA_W-1:0]     usrRdData,
  output logic [DATA_W-1:0]     cpsrOut,
  output logic [DATA_W-1:0]     spsrOut
);

  localparam int NUM_GPR   = 1 << REG_ADDR_W;
  localparam int FIQ_LO    = 8;
  localparam int FIQ_CNT   = 5;
  localparam int FIQ_BASE  = NUM_GPR;
  localparam int STK_BASE  = FIQ_BASE + FIQ_CNT;
  localparam int NUM_PHYS  = STK_BASE + 2 * NUM_PRIV;
  localparam int PIDX_W    = $clog2(NUM_PHYS);
  localparam logic [DATA_W-1:0] CPSR_RST = DATA_W'(32'h0000_001F);

  // Map an architectural index plus bank to a physical slot
  function automatic logic [PIDX_W-1:0] physIdx(input logic [REG_ADDR_W-1:0] a,
                                                 input bankT bk);
    int v;
    v = int'(a);
    if (bk == BK_FIQ && v >= FIQ_LO && v < FIQ_LO + FIQ_CNT)
      v = FIQ_BASE + v - FIQ_LO;
    else if (bk != BK_USR && (v == 13 || v == 14))
      v = STK_BASE + 2 * (int'(bk) - 1) + v - 13;
    return PIDX_W'(v);
  endfunction

  logic [DATA_W-1:0] regs  [NUM_PHYS];
  logic [DATA_W-1:0] spsrs [NUM_PRIV];
  logic [DATA_W-1:0] cpsr;

  logic [PIDX_W-1:0] wrIdx, usrIdx;
  logic [2:0]        spsrWrIdx, spsrRdIdx;

  assign wrIdx     = physIdx(wrAddr, stb.wrBank);
  assign usrIdx    = physIdx(usrWrAddr, BK_USR);
  assign spsrWrIdx = 3'(stb.wrBank) - 3'd1;
  assign spsrRdIdx = 3'(stb.curBank) - 3'd1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PHYS; i++) regs[i] <= '0;
      for (int j = 0; j < NUM_PRIV; j++) spsrs[j] <= '0;
      cpsr <= CPSR_RST;
    end else begin
      if (stb.usrWr)    regs[usrIdx] <= usrWrData;
      if (stb.gprWr)    regs[wrIdx]  <= wrData;   // normal port wins on a clash
      if (stb.spsrWr)   spsrs[spsrWrIdx] <= spsrWrData;
      if (stb.cpsrLoad) cpsr <= psrWrData;
    end
  end

  assign rdDataA   = regs[physIdx(rdAddrA, stb.curBank)];
  assign rdDataB   = regs[physIdx(rdAddrB, stb.curBank)];
  assign usrRdData = regs[physIdx(usrRdAddr, BK_USR)];
  assign cpsrOut   = cpsr;
  assign spsrOut   = (stb.curBank == BK_USR) ? '0 : spsrs[spsrRdIdx];

endmodule

// File: rtl/bankedRegFile.sv
module bankedRegFile
  import bankRegPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [3:0]        rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [3:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [3:0]        usrRdAddr,
  output logic [DATA_W-1:0] usrRdData,
  input  logic              usrWrEn,
  input  logic [3:0]        usrWrAddr,
  input  logic [DATA_W-1:0] usrWrData,
  input  logic              psrWrEn,
  input  logic [DATA_W-1:0] psrWrData,
  input  logic              spsrWrEn,
  input  logic [DATA_W-1:0] spsrWrData,
  output logic [DATA_W-1:0] cpsrOut,
  output logic [DATA_W-1:0] spsrOut,
  output logic              hasSpsr,
  output logic              privileged,
  output logic              modeErr
);

  strobeT stb;

  bankCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .curMode    (cpsrOut[4:0]),
    .psrWrEn    (psrWrEn),
    .psrWrMode  (psrWrData[4:0]),
    .wrEn       (wrEn),
    .usrWrEn    (usrWrEn),
    .spsrWrEn   (spsrWrEn),
    .stb        (stb),
    .modeErr    (modeErr),
    .hasSpsr    (hasSpsr),
    .privileged (privileged)
  );

  bankDatapath #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .rdAddrA    (rdAddrA),
    .rdAddrB    (rdAddrB),
    .usrRdAddr  (usrRdAddr),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .usrWrAddr  (usrWrAddr),
    .usrWrData  (usrWrData),
    .psrWrData  (psrWrData),
    .spsrWrData (spsrWrData),
    .rdDataA    (rdDataA),
    .rdDataB    (rdDataB),
    .usrRdData  (usrRdData),
    .cpsrOut    (cpsrOut),
    .spsrOut    (spsrOut)
  );

endmodule

// File: rtl/bankedRegFileChk.sv
module bankedRegFileChk
  import bankRegPkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [3:0]        rdAddrA,
  input logic [DATA_W-1:0] rdDataA,
  input logic              wrEn,
  input logic              usrWrEn,
  input logic              psrWrEn,
  input logic [DATA_W-1:0] psrWrData,
  input logic [DATA_W-1:0] cpsrOut,
  input logic [DATA_W-1:0] spsrOut,
  input logic              hasSpsr,
  input logic              privileged,
  input logic              modeErr
);

  logic curUsrSys;
  assign curUsrSys = (cpsrOut[4:0] == MODE_USR) || (cpsrOut[4:0] == MODE_SYS);

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    modeLegal(cpsrOut[4:0])); // R2

  AST_BAD_MODE_DROP: assert property (@(posedge clk) disable iff (!rstN)
    psrWrEn && !modeLegal(psrWrData[4:0]) |=> modeErr && $stable(cpsrOut)); // R2

  AST_GOOD_MODE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    psrWrEn && modeLegal(psrWrData[4:0]) |=> (cpsrOut == $past(psrWrData)) && !modeErr); // R9

  AST_NO_SPSR_USRSYS: assert property (@(posedge clk) disable iff (!rstN)
    curUsrSys |-> !hasSpsr && (spsrOut == '0)); // R5

  AST_PRIV_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (cpsrOut[4:0] == MODE_USR) |-> !privileged); // R10

  AST_LOW_REGS_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !usrWrEn && rdAddrA < 4'd8) ##1 $stable(rdAddrA) |-> $stable(rdDataA)); // R6

endmodule

bind bankedRegFile bankedRegFileChk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rdAddrA    (rdAddrA),
  .rdDataA    (rdDataA),
  .wrEn       (wrEn),
  .usrWrEn    (usrWrEn),
  .psrWrEn    (psrWrEn),
  .psrWrData  (psrWrData),
  .cpsrOut    (cpsrOut),
  .spsrOut    (spsrOut),
  .hasSpsr    (hasSpsr),
  .privileged (privileged),
  .modeErr    (modeErr)
);

// File: tb/bankedRegFile_tb.sv
`timescale 1ns/1ps
module bankedRegFile_tb;

  localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                         SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011,
                         SYS = 5'b11111;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0, usrRdAddr = '0, usrWrAddr = '0;
  logic [31:0] wrData = '0, usrWrData = '0, psrWrData = '0, spsrWrData = '0;
  logic        wrEn = 1'b0, usrWrEn = 1'b0, psrWrEn = 1'b0, spsrWrEn = 1'b0;
  logic [31:0] rdDataA, rdDataB, usrRdData, cpsrOut, spsrOut;
  logic        hasSpsr, privileged, modeErr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  bankedRegFile u_dut (
    .clk(clk), .rstN(rstN),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .usrRdAddr(usrRdAddr), .usrRdData(usrRdData),
    .usrWrEn(usrWrEn), .usrWrAddr(usrWrAddr), .usrWrData(usrWrData),
    .psrWrEn(psrWrEn), .psrWrData(psrWrData),
    .spsrWrEn(spsrWrEn), .spsrWrData(spsrWrData),
    .cpsrOut(cpsrOut), .spsrOut(spsrOut), .hasSpsr(hasSpsr),
    .privileged(privileged), .modeErr(modeErr)
  );

  // Behavioural reference: per-mode tables keyed by mode code
  logic [31:0] mCommon [16];
  logic [31:0] mFast   [5];
  logic [31:0] mSp     [32];
  logic [31:0] mLr     [32];
  logic [31:0] mSaved  [32];
  logic [31:0] mCpsr;
  logic        mErr;

  function automatic bit legal(input logic [4:0] m);
    return m inside {USR, FIQ, IRQ, SVC, ABT, UND, SYS};
  endfunction

  function automatic bit ownBank(input logic [4:0] m);
    return !(m == USR || m == SYS);
  endfunction

  function automatic logic [31:0] mRead(input logic [3:0] a, input logic [4:0] m);
    int k = int'(a);
    if (m == FIQ && k >= 8 && k <= 12) return mFast[k-8];
    if (ownBank(m) && k == 13) return mSp[m];
    if (ownBank(m) && k == 14) return mLr[m];
    return mCommon[k];
  endfunction

  task automatic mWrite(input logic [3:0] a, input logic [4:0] m, input logic [31:0] d);
    int k = int'(a);
    if (m == FIQ && k >= 8 && k <= 12) mFast[k-8] = d;
    else if (ownBank(m) && k == 13) mSp[m] = d;
    else if (ownBank(m) && k == 14) mLr[m] = d;
    else mCommon[k] = d;
  endtask

  task automatic mReset();
    for (int i = 0; i < 16; i++) mCommon[i] = '0;
    for (int i = 0; i < 5; i++)  mFast[i] = '0;
    for (int i = 0; i < 32; i++) begin mSp[i] = '0; mLr[i] = '0; mSaved[i] = '0; end
    mCpsr = 32'h0000_001F;
    mErr  = 1'b0;
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Compare all outputs, then let one edge pass and advance the model
  task automatic cyc(input string tag);
    logic [4:0] cur, nxt;
    #1;
    cur = mCpsr[4:0];
    chk(tag, "rdDataA", rdDataA, mRead(rdAddrA, cur));
    chk(tag, "rdDataB", rdDataB, mRead(rdAddrB, cur));
    chk(tag, "usrRdData", usrRdData, mRead(usrRdAddr, USR));
    chk(tag, "cpsrOut", cpsrOut, mCpsr);
    chk(tag, "spsrOut", spsrOut, ownBank(cur) ? mSaved[cur] : 32'h0);
    chk(tag, "hasSpsr", {31'b0, hasSpsr}, {31'b0, ownBank(cur)});
    chk(tag, "privileged", {31'b0, privileged}, {31'b0, cur != USR});
    chk(tag, "modeErr", {31'b0, modeErr}, {31'b0, mErr});
    @(posedge clk);
    if (rstN) begin
      nxt = (psrWrEn && legal(psrWrData[4:0])) ? psrWrData[4:0] : cur;
      if (usrWrEn) mWrite(usrWrAddr, USR, usrWrData);
      if (wrEn)    mWrite(wrAddr, nxt, wrData);
      if (spsrWrEn && ownBank(nxt)) mSaved[nxt] = spsrWrData;
      if (psrWrEn && legal(psrWrData[4:0])) mCpsr = psrWrData;
      mErr = psrWrEn && !legal(psrWrData[4:0]);
    end else begin
      mReset();
    end
    @(negedge clk);
  endtask

  task automatic idle();
    wrEn = 0; usrWrEn = 0; psrWrEn = 0; spsrWrEn = 0;
  endtask

  task automatic setMode(input logic [4:0] m, input logic [7:0] flags);
    psrWrEn = 1; psrWrData = {flags[3:0], 20'h0, flags[7:5], m};
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [4:0] modes [7];
    modes = '{USR, FIQ, IRQ, SVC, ABT, UND, SYS};
    mReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rdAddrA = 4'd13; rdAddrB = 4'd8; usrRdAddr = 4'd14;
    cyc("R1");                      // still in reset
    rstN = 1;
    cyc("R1");

    // R11: fill common registers in system mode, reading back one behind
    for (int i = 0; i < 16; i++) begin
      wrEn = 1; wrAddr = 4'(i); wrData = 32'hA000_0000 + 32'(i);
      rdAddrA = 4'(i); rdAddrB = 4'(i == 0 ? 0 : i - 1);
      cyc("R11");
    end
    idle();

    // R9 / R3: enter fast interrupt, fast copies start at zero
    setMode(FIQ, 8'hC0); rdAddrA = 4'd8; rdAddrB = 4'd12;
    cyc("R9");
    idle();
    cyc("R3");
    wrEn = 1; wrAddr = 4'd8; wrData = 32'hF1F1_0008;
    cyc("R3");
    wrEn = 1; wrAddr = 4'd13; wrData = 32'hF1F1_000D;
    usrRdAddr = 4'd8;
    cyc("R7");
    idle(); rdAddrA = 4'd0; rdAddrB = 4'd15; usrRdAddr = 4'd13;
    cyc("R6");

    // R8: mode change with register and saved-status writes in one cycle
    setMode(IRQ, 8'h80); wrEn = 1; wrAddr = 4'd13; wrData = 32'h1111_000D;
    spsrWrEn = 1; spsrWrData = 32'h6000_0011; rdAddrA = 4'd13; rdAddrB = 4'd8;
    cyc("R8");
    idle();
    cyc("R8");

    // R4: user and system share r13/r14
    setMode(USR, 8'h00); rdAddrA = 4'd13; rdAddrB = 4'd14;
    cyc("R4");
    idle(); wrEn = 1; wrAddr = 4'd14; wrData = 32'h5555_000E;
    cyc("R10");
    idle(); setMode(SYS, 8'h00);
    cyc("R4");
    idle();
    cyc("R4");

    // R5: saved-status write ignored in system mode, kept per mode
    spsrWrEn = 1; spsrWrData = 32'hDEAD_BEEF;
    cyc("R5");
    idle(); setMode(SVC, 8'h00);
    cyc("R5");
    idle(); spsrWrEn = 1; spsrWrData = 32'h2000_0013;
    cyc("R5");
    idle(); setMode(ABT, 8'h00);
    cyc("R5");
    idle(); setMode(SVC, 8'h00);
    cyc("R5");
    idle();
    cyc("R5");

    // R7: user-view write from supervisor, R11 clash with normal port
    usrWrEn = 1; usrWrAddr = 4'd13; usrWrData = 32'h7777_000D; usrRdAddr = 4'd13;
    cyc("R7");
    idle(); usrWrEn = 1; usrWrAddr = 4'd3; usrWrData = 32'h0BAD_0003;
    wrEn = 1; wrAddr = 4'd3; wrData = 32'h600D_0003; rdAddrA = 4'd3;
    cyc("R11");
    idle();
    cyc("R11");

    // R2: illegal mode code rejected
    psrWrEn = 1; psrWrData = 32'h0000_0015;
    cyc("R2");
    idle();
    cyc("R2");
    cyc("R2");

    // Random mix checked every cycle against the model
    for (int n = 0; n < 600; n++) begin
      logic [4:0] m;
      m = modes[$urandom_range(0, 6)];
      if ($urandom_range(0, 15) == 0) m = 5'($urandom);
      psrWrEn   = ($urandom_range(0, 3) == 0);
      psrWrData = {$urandom} & 32'hF000_00E0 | {27'b0, m};
      wrEn      = $urandom_range(0, 1);
      wrAddr    = 4'($urandom); wrData = $urandom;
      usrWrEn   = ($urandom_range(0, 3) == 0);
      usrWrAddr = 4'($urandom_range(8, 15)); usrWrData = $urandom;
      spsrWrEn  = ($urandom_range(0, 3) == 0); spsrWrData = $urandom;
      rdAddrA   = 4'($urandom); rdAddrB = 4'($urandom_range(8, 14));
      usrRdAddr = 4'($urandom);
      cyc("R9");
    end
    idle();
    cyc("R9");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule